// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Multiplexers

This block gathers thirty-one peripheral interrupt sources into seven small groups. Each group reports its sources through a live status register and can block any of them through a mask register. A group drives one fixed input line of the primary interrupt controller. That line is asserted while at least one source of the group is asserted and not blocked. A set mask bit blocks its source, and a cleared bit lets it through.

Software reads a group's status, removes the blocked bits and services each remaining source. It keeps reading until nothing unblocked is left. The primary line therefore tracks the source levels and never latches an event. Both kinds of register sit on a shared register bus at fixed, irregular byte offsets. The primary controller and any device-specific clearing of a source are outside this block.

Top module: `casc_irq_mux`

## Requirements
- R1: There are seven groups, of sizes 2, 2, 3, 5, 15, 2 and 2. The status registers are at byte offsets 0x150, 0x154, 0x180, 0x158, 0x15C, 0x160 and 0x188, in that group order. Status bit n reads the live level of source n of that group, and bits at or above the group size read 0. Source input bits are packed from group 0 upward, each group starting at the sum of the sizes of the groups before it.
- R2: The mask registers are at byte offsets 0x168, 0x16C, 0x17C, 0x170, 0x174, 0x178 and 0x184, in the same group order. A write stores the low group-size bits of the write data. A read returns them, with bits at or above the group size reading 0.
- R3: After reset every mask bit is 1, so every source is blocked and no primary line is asserted.
- R4: Groups 0 to 6 drive primary lines 4, 5, 9, 17, 35, 51 and 55 respectively. A group's line is 1 exactly when its status AND NOT its mask is non-zero, and a set mask bit blocks its source.
- R5: A primary line is registered. It reflects the sources and mask of the previous clock edge and drops as soon as the unblocked set becomes empty, with no latching.
- R6: Writes to a status offset have no effect on any register or line.
- R7: A read from any offset that holds no register returns 0. Primary lines other than the seven listed are always 0.
- R8: Read data is registered and shows the register addressed at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_i | input | 31 | Source levels, groups packed from bit 0 |
| pri_irq_o | output | 64 | Lines to the primary controller |

## Verification
The bench builds the block with its default 12-bit offsets, 32-bit data and 64 primary lines, so the real seven-group layout is the configuration under test. Because the groups are so small, every source-and-mask combination can be swept for the groups of up to five sources. The fifteen-source group is covered by 256 arithmetically spread pairs plus its all-zero and all-one corners. Each combination compares the whole 64-bit primary vector, the status readback and the mask readback, so a wrong line number, offset or bit width shows up directly.

// File: rtl/cmux_pkg.sv
package cmux_pkg;
  localparam int NGRP = 7;
  localparam int GSIZE    [NGRP] = '{2, 2, 3, 5, 15, 2, 2};
  localparam int GLINE    [NGRP] = '{4, 5, 9, 17, 35, 51, 55};
  localparam int STAT_OFS [NGRP] = '{'h150, 'h154, 'h180, 'h158, 'h15C, 'h160, 'h188};
  localparam int MASK_OFS [NGRP] = '{'h168, 'h16C, 'h17C, 'h170, 'h174, 'h178, 'h184};

  function automatic int src_base(int g);
    int acc;
    acc = 0;
    for (int k = 0; k < g; k++) acc += GSIZE[k];
    return acc;
  endfunction

  localparam int SRC_W = src_base(NGRP);
endpackage

// File: rtl/cmux_group.sv
module cmux_group #(
  parameter int SIZE   = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SIZE-1:0]   src_i,
  input  logic              mask_we,
  input  logic [DATA_W-1:0] mask_wdata,
  output logic [DATA_W-1:0] mask_rd,
  output logic              irq_o
);
  logic [SIZE-1:0] mask_q;
  logic            irq_q;
  logic [SIZE-1:0] live;

  assign live = src_i & ~mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata[SIZE-1:0];
      irq_q <= |live;
    end
  end

  assign mask_rd = DATA_W'(mask_q);
  assign irq_o   = irq_q;

  generate
    if (SIZE < DATA_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = |mask_wdata[DATA_W-1:SIZE];
    end
  endgenerate

  // R3
  mask_rst_chk: assert property (@(posedge clk) rst |=> (mask_q == '1 && !irq_q));
  // R2
  mask_wr_chk: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> mask_q == $past(mask_wdata[SIZE-1:0]));
  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mask_we |=> $stable(mask_q));
  // R5
  irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ((src_i & ~mask_q) == '0) |=> !irq_o);
  // R4
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ((src_i & ~mask_q) != '0) |=> irq_o);
endmodule

// File: rtl/cmux_regmux.sv
module cmux_regmux #(
  parameter int NG     = 7,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NG-1:0][DATA_W-1:0]  stat_v,
  input  logic [NG-1:0][DATA_W-1:0]  mask_v,
  output logic [DATA_W-1:0]          rdata
);
  import cmux_pkg::*;

  logic [DATA_W-1:0] sel;
  logic [2*NG-1:0]   hit;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    sel = '0;
    hit = '0;
    for (int g = 0; g < NG; g++) begin
      if (addr == ADDR_W'(STAT_OFS[g])) begin
        sel      = sel | stat_v[g];
        hit[g]   = 1'b1;
      end
      if (addr == ADDR_W'(MASK_OFS[g])) begin
        sel         = sel | mask_v[g];
        hit[NG + g] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= sel;
  end

  assign rdata = rdata_q;

  // R7
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (hit == '0) |=> rdata == '0);
  // R8
  read_stat_chk: assert property (@(posedge clk) disable iff (rst)
    (hit[NG-1:0] != '0) |=> rdata == $past(sel));
endmodule

// File: rtl/casc_irq_mux.sv
module casc_irq_mux #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int PRI_W  = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [cmux_pkg::SRC_W-1:0] src_i,
  output logic [PRI_W-1:0]           pri_irq_o
);
  import cmux_pkg::*;

  logic [NGRP-1:0]             grp_irq;
  logic [NGRP-1:0]             mask_we;
  logic [NGRP-1:0][DATA_W-1:0] stat_v;
  logic [NGRP-1:0][DATA_W-1:0] mask_v;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int SZ   = GSIZE[g];
    localparam int BASE = src_base(g);

    assign mask_we[g] = bus_we && (bus_addr == ADDR_W'(MASK_OFS[g]));
    assign stat_v[g]  = DATA_W'(src_i[BASE +: SZ]);

    cmux_group #(.SIZE(SZ), .DATA_W(DATA_W)) u_grp (
      .clk        (clk),
      .rst        (rst),
      .src_i      (src_i[BASE +: SZ]),
      .mask_we    (mask_we[g]),
      .mask_wdata (bus_wdata),
      .mask_rd    (mask_v[g]),
      .irq_o      (grp_irq[g])
    );
  end

  cmux_regmux #(.NG(NGRP), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .clk    (clk),
    .rst    (rst),
    .addr   (bus_addr),
    .stat_v (stat_v),
    .mask_v (mask_v),
    .rdata  (bus_rdata)
  );

  always_comb begin
    pri_irq_o = '0;
    for (int g = 0; g < NGRP; g++) pri_irq_o[GLINE[g]] = grp_irq[g];
  end

  // R7
  spare_lines_chk: assert property (@(posedge clk)
    $countones(pri_irq_o) <= NGRP);
endmodule

// File: tb/casc_irq_mux_test.sv
module casc_irq_mux_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [30:0] src = '0;
  logic [63:0] pri;

  int checks = 0;
  int fails  = 0;

  localparam int SZ  [7] = '{2, 2, 3, 5, 15, 2, 2};
  localparam int LN  [7] = '{4, 5, 9, 17, 35, 51, 55};
  localparam int SOF [7] = '{'h150, 'h154, 'h180, 'h158, 'h15C, 'h160, 'h188};
  localparam int MOF [7] = '{'h168, 'h16C, 'h17C, 'h170, 'h174, 'h178, 'h184};

  casc_irq_mux uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_i(src), .pri_irq_o(pri)
  );

  always #10 clk = ~clk;

  function automatic int base_of(int g);
    int b = 0;
    for (int k = 0; k < g; k++) b += SZ[k];
    return b;
  endfunction

  function automatic logic [31:0] ones(int n);
    return (32'h1 << n) - 32'h1;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); bus_addr = 12'(a);
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = 12'(a); bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic combo(int g, int s, int m);
    logic [63:0] exp;
    @(negedge clk);
    src = 31'(s) << base_of(g);
    bus_we = 1'b1; bus_addr = 12'(MOF[g]); bus_wdata = 32'(m) | ~ones(SZ[g]);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 12'(SOF[g]);
    @(negedge clk);
    chk("R1 status", 64'(bus_rdata), 64'(s));
    exp = ((s & ~m & ones(SZ[g])) != 0) ? (64'h1 << LN[g]) : 64'h0;
    chk("R4 line", pri, exp);
    bus_addr = 12'(MOF[g]);
    @(negedge clk);
    chk("R2 mask readback", 64'(bus_rdata), 64'(m & ones(SZ[g])));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    src = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R3 no line after reset", pri, 64'h0);
    for (int g = 0; g < 7; g++) begin
      rd(MOF[g], d); chk("R3 mask reset", 64'(d), 64'(ones(SZ[g])));
      rd(SOF[g], d); chk("R1 status width", 64'(d), 64'(ones(SZ[g])));
    end
    chk("R3 still blocked", pri, 64'h0);
    src = '0;

    foreach (SZ[g]) begin
      if (SZ[g] <= 5) begin
        for (int s = 0; s < (1 << SZ[g]); s++)
          for (int m = 0; m < (1 << SZ[g]); m++) combo(g, s, m);
      end else begin
        combo(g, 0, 0);
        combo(g, 'h7FFF, 0);
        combo(g, 'h7FFF, 'h7FFF);
        for (int k = 0; k < 256; k++)
          combo(g, (k * 1237 + 91) & 'h7FFF, (k * 4093 + 7 * k * k) & 'h7FFF);
      end
    end

    // R5: line drops when the unblocked source goes away
    combo(3, 'h4, 'h1B);
    @(negedge clk); src = '0;
    @(negedge clk); chk("R5 drop after edge", pri, 64'h0);
    @(negedge clk); src = 31'h4 << base_of(3);
    @(negedge clk); chk("R5 rise again", pri, 64'h1 << 17);

    // R6: status writes ignored
    src = '0;
    wr(SOF[4], 32'hFFFF_FFFF);
    rd(SOF[4], d); chk("R6 status write ignored", 64'(d), 64'h0);
    rd(MOF[4], d); chk("R6 mask untouched", 64'(d), 64'(((255 * 4093 + 7 * 255 * 255) & 'h7FFF)));
    chk("R6 no line", pri, 64'h0);

    // R7: unmapped offsets read zero
    src = '1;
    rd('h000, d); chk("R7 unmapped 0x000", 64'(d), 64'h0);
    rd('h14C, d); chk("R7 unmapped 0x14C", 64'(d), 64'h0);
    rd('h164, d); chk("R7 unmapped 0x164", 64'(d), 64'h0);
    rd('hFFC, d); chk("R7 unmapped 0xFFC", 64'(d), 64'h0);

    // R8: data lags the address by one edge
    @(negedge clk); bus_addr = 12'(SOF[0]);
    @(negedge clk); bus_addr = 12'h000;
    chk("R8 registered read", 64'(bus_rdata), 64'h3);
    @(negedge clk);
    chk("R8 next read", 64'(bus_rdata), 64'h0);
    finish_run();
  end
endmodule